// File: doc/BRIEF.md
# Integer ALU with Four-Entry Register File and Condition Flags

This block is a 32-bit integer execution unit that keeps four data registers and a four-bit status word (zero, negative, carry, overflow). On each clock edge with a valid request it performs one of six operations: add, subtract, compare, OR, XOR or bit test. The result is written back to the selected register when the operation calls for it, and all four flags are updated on that same edge.

One operand always comes from the external `srcVal` input. The other is the register picked by `dstSel`. Compare and bit test can take `auxVal` in place of that register when `explicitOps` is high. Carry means borrow for subtract and compare. Compare subtracts the external value from the register or auxiliary value. The logical operations and bit test always clear carry and overflow. Every register and the status word are brought out on ports so that a surrounding model can compare its state on every cycle.

Top module: `cond_alu`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears all four registers and `statusOut` to zero. `statusOut` bit 0 is Z, bit 1 is N, bit 2 is C and bit 3 is V. Register i appears on `regsOut[32*i+31:32*i]`.
- R2: ADD (opCode 0) writes reg+src to the selected register. C is set when the unsigned 32-bit sum wraps. V is set when both operands share a sign bit and the sum's sign differs from it.
- R3: SUB (opCode 1) writes reg−src to the selected register. C is set when src is greater than reg as unsigned numbers (borrow). V is set when the operand signs differ and the result's sign differs from reg's sign.
- R4: CMP (opCode 2) computes right−src, where right is the selected register (or `auxVal`, see R8). It writes no register. C is set when src is greater than right as unsigned numbers. V follows the R3 rule with right as the minuend.
- R5: OR (opCode 3) and XOR (opCode 4) write reg|src and reg^src respectively to the selected register, and they clear C and V.
- R6: Bit test (opCode 5) forms src AND right, writes no register, sets Z and N from that value, and clears C and V.
- R7: For every valid operation, Z is set exactly when the 32-bit result is zero, and N equals bit 31 of the result.
- R8: When `explicitOps` is high, CMP and bit test use `auxVal` as the right operand. For ADD, SUB, OR and XOR, `explicitOps` and `auxVal` have no effect.
- R9: When `opValid` is low, or when opCode is 6 or 7, no register and no flag changes.
- R10: A write operation changes only the register named by `dstSel`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| opValid | input | 1 | Request an operation on this edge |
| opCode | input | 3 | Operation: 0 add, 1 sub, 2 cmp, 3 or, 4 xor, 5 bit test |
| dstSel | input | 2 | Register index used as operand and write target |
| srcVal | input | 32 | External source operand |
| explicitOps | input | 1 | Compare/bit test take `auxVal` instead of the register |
| auxVal | input | 32 | Explicit right operand for compare/bit test |
| statusOut | output | 4 | Flags {V,C,N,Z} |
| regsOut | output | 128 | All four registers, register 0 in the low word |

## Verification
All state is visible at the ports one edge after the request, so a wrong write target, a stray write on compare or bit test, or a miscomputed flag shows on `regsOut` or `statusOut` at the first sample after the faulty operation. Errors in the carry and overflow rules only appear for particular operand signs and magnitudes. For that reason, wrap, borrow, signed overflow in both directions, a zero result and reversed compare order are each driven on purpose. Operations that must leave state alone are checked by sampling every register and flag right after them.

// File: rtl/cond_alu_pkg.sv
package cond_alu_pkg;

  localparam int OPC_W = 3;

  typedef enum logic [OPC_W-1:0] {
    OPC_ADD = 3'd0,
    OPC_SUB = 3'd1,
    OPC_CMP = 3'd2,
    OPC_OR  = 3'd3,
    OPC_XOR = 3'd4,
    OPC_TST = 3'd5
  } opc_e;

  typedef enum logic [2:0] {
    FN_ADD = 3'd0,
    FN_SUB = 3'd1,
    FN_OR  = 3'd2,
    FN_XOR = 3'd3,
    FN_AND = 3'd4
  } aluFn_e;

  // Positions inside the status word
  localparam int FLG_Z = 0;
  localparam int FLG_N = 1;
  localparam int FLG_C = 2;
  localparam int FLG_V = 3;
  localparam int FLG_W = 4;

  typedef struct packed {
    logic   wrEn;    // commit result to the selected register
    logic   flagEn;  // commit new flags
    logic   useAux;  // right operand from auxVal instead of register
    aluFn_e fn;
  } ctrlStrobe_t;

endpackage

// File: rtl/cond_alu_ctrl.sv
module cond_alu_ctrl
  import cond_alu_pkg::*;
(
  input  logic             opValid,
  input  logic [OPC_W-1:0] opCode,
  input  logic             explicitOps,
  output ctrlStrobe_t      strobe
);

  always_comb begin
    strobe        = '0;
    strobe.fn     = FN_ADD;
    if (opValid) begin
      case (opCode)
        OPC_ADD: begin
          strobe.wrEn   = 1'b1;
          strobe.flagEn = 1'b1;
          strobe.fn     = FN_ADD;
        end
        OPC_SUB: begin
          strobe.wrEn   = 1'b1;
          strobe.flagEn = 1'b1;
          strobe.fn     = FN_SUB;
        end
        OPC_CMP: begin
          strobe.flagEn = 1'b1;
          strobe.useAux = explicitOps;
          strobe.fn     = FN_SUB;
        end
        OPC_OR: begin
          strobe.wrEn   = 1'b1;
          strobe.flagEn = 1'b1;
          strobe.fn     = FN_OR;
        end
        OPC_XOR: begin
          strobe.wrEn   = 1'b1;
          strobe.flagEn = 1'b1;
          strobe.fn     = FN_XOR;
        end
        OPC_TST: begin
          strobe.flagEn = 1'b1;
          strobe.useAux = explicitOps;
          strobe.fn     = FN_AND;
        end
        default: strobe = '0;
      endcase
    end
  end

endmodule

// File: rtl/cond_alu_fn.sv
module cond_alu_fn
  import cond_alu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  aluFn_e            fn,
  input  logic [DATA_W-1:0] opA,   // register / right operand
  input  logic [DATA_W-1:0] opB,   // external source / left operand
  output logic [DATA_W-1:0] result,
  output logic [FLG_W-1:0]  flags
);

  localparam int MSB = DATA_W - 1;

  logic [DATA_W:0] sumExt;
  logic [DATA_W:0] diffExt;
  logic            carry;
  logic            ovf;

  assign sumExt  = {1'b0, opA} + {1'b0, opB};
  assign diffExt = {1'b0, opA} - {1'b0, opB};

  always_comb begin
    result = '0;
    carry  = 1'b0;
    ovf    = 1'b0;
    case (fn)
      FN_ADD: begin
        result = sumExt[MSB:0];
        carry  = sumExt[DATA_W];
        ovf    = (opA[MSB] == opB[MSB]) && (result[MSB] != opA[MSB]);
      end
      FN_SUB: begin
        result = diffExt[MSB:0];
        carry  = diffExt[DATA_W];  // borrow out
        ovf    = (opA[MSB] != opB[MSB]) && (result[MSB] != opA[MSB]);
      end
      FN_OR:   result = opA | opB;
      FN_XOR:  result = opA ^ opB;
      FN_AND:  result = opA & opB;
      default: result = '0;
    endcase
  end

  always_comb begin
    flags        = '0;
    flags[FLG_Z] = (result == '0);
    flags[FLG_N] = result[MSB];
    flags[FLG_C] = carry;
    flags[FLG_V] = ovf;
  end

endmodule

// File: rtl/cond_alu_dpath.sv
module cond_alu_dpath
  import cond_alu_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int REG_CNT = 4,
  localparam int SEL_W  = $clog2(REG_CNT)
) (
  input  logic                      clk,
  input  logic                      rst,
  input  ctrlStrobe_t               strobe,
  input  logic [SEL_W-1:0]          dstSel,
  input  logic [DATA_W-1:0]         srcVal,
  input  logic [DATA_W-1:0]         auxVal,
  output logic [FLG_W-1:0]          statusOut,
  output logic [REG_CNT*DATA_W-1:0] regsOut
);

  logic [DATA_W-1:0] regFile [REG_CNT];
  logic [DATA_W-1:0] selReg;
  logic [DATA_W-1:0] opA;
  logic [DATA_W-1:0] aluResult;
  logic [FLG_W-1:0]  aluFlags;
  logic [FLG_W-1:0]  statusQ;
  logic [REG_CNT-1:0] wrVec;

  assign selReg = regFile[dstSel];
  assign opA    = strobe.useAux ? auxVal : selReg;

  cond_alu_fn #(.DATA_W(DATA_W)) uFn (
    .fn     (strobe.fn),
    .opA    (opA),
    .opB    (srcVal),
    .result (aluResult),
    .flags  (aluFlags)
  );

  for (genvar i = 0; i < REG_CNT; i++) begin : gReg
    assign wrVec[i] = strobe.wrEn && (dstSel == SEL_W'(i));

    always_ff @(posedge clk) begin
      if (rst)           regFile[i] <= '0;
      else if (wrVec[i]) regFile[i] <= aluResult;
    end

    assign regsOut[i*DATA_W +: DATA_W] = regFile[i];
  end

  always_ff @(posedge clk) begin
    if (rst)              statusQ <= '0;
    else if (strobe.flagEn) statusQ <= aluFlags;
  end

  assign statusOut = statusQ;

  // Assertions
  AST_ONE_WRITE: assert property (@(posedge clk) disable iff (rst)
    $onehot0(wrVec)); // R10

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !strobe.flagEn |=> $stable(statusOut) && $stable(regsOut)); // R9

  AST_NO_WRITE_CMP_TST: assert property (@(posedge clk) disable iff (rst)
    (strobe.flagEn && !strobe.wrEn) |=> $stable(regsOut)); // R4 R6

  AST_LOGIC_CV_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (strobe.flagEn && (strobe.fn inside {FN_OR, FN_XOR, FN_AND}))
      |=> (statusOut[FLG_C] == 1'b0) && (statusOut[FLG_V] == 1'b0)); // R5

  AST_ZERO_TRACKS_REG: assert property (@(posedge clk) disable iff (rst)
    strobe.wrEn |=> statusOut[FLG_Z] == (regFile[$past(dstSel)] == '0)); // R7

  AST_NEG_TRACKS_REG: assert property (@(posedge clk) disable iff (rst)
    strobe.wrEn |=> statusOut[FLG_N] == regFile[$past(dstSel)][DATA_W-1]); // R7

endmodule

// File: rtl/cond_alu.sv
module cond_alu
  import cond_alu_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int REG_CNT = 4,
  localparam int SEL_W  = $clog2(REG_CNT)
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      opValid,
  input  logic [2:0]                opCode,
  input  logic [SEL_W-1:0]          dstSel,
  input  logic [DATA_W-1:0]         srcVal,
  input  logic                      explicitOps,
  input  logic [DATA_W-1:0]         auxVal,
  output logic [3:0]                statusOut,
  output logic [REG_CNT*DATA_W-1:0] regsOut
);

  ctrlStrobe_t strobe;

  cond_alu_ctrl uCtrl (
    .opValid     (opValid),
    .opCode      (opCode),
    .explicitOps (explicitOps),
    .strobe      (strobe)
  );

  cond_alu_dpath #(.DATA_W(DATA_W), .REG_CNT(REG_CNT)) uDpath (
    .clk       (clk),
    .rst       (rst),
    .strobe    (strobe),
    .dstSel    (dstSel),
    .srcVal    (srcVal),
    .auxVal    (auxVal),
    .statusOut (statusOut),
    .regsOut   (regsOut)
  );

  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (statusOut == '0) && (regsOut == '0)); // R1

endmodule

// File: tb/tb_cond_alu.sv
module tb_cond_alu;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         opValid = 1'b0;
  logic [2:0]   opCode = '0;
  logic [1:0]   dstSel = '0;
  logic [31:0]  srcVal = '0;
  logic         explicitOps = 1'b0;
  logic [31:0]  auxVal = '0;
  logic [3:0]   statusOut;
  logic [127:0] regsOut;

  int total = 0;
  int bad   = 0;
  bit finished = 1'b0;

  logic [31:0] mReg [4];
  logic [3:0]  mStat;   // {V,C,N,Z}

  always #2.5 clk = ~clk;

  cond_alu dut (
    .clk(clk), .rst(rst), .opValid(opValid), .opCode(opCode),
    .dstSel(dstSel), .srcVal(srcVal), .explicitOps(explicitOps),
    .auxVal(auxVal), .statusOut(statusOut), .regsOut(regsOut)
  );

  task automatic checkState(input string req);
    for (int i = 0; i < 4; i++) begin
      total++;
      if (regsOut[i*32 +: 32] !== mReg[i]) begin
        bad++;
        $display("FAIL %s reg%0d actual=%h expected=%h", req, i, regsOut[i*32 +: 32], mReg[i]);
      end
    end
    total++;
    if (statusOut !== mStat) begin
      bad++;
      $display("FAIL %s status actual=%b expected=%b", req, statusOut, mStat);
    end
  endtask

  // Reference behaviour written from the requirements
  task automatic model(input logic [2:0] op, input logic [1:0] d,
                       input logic [31:0] s, input logic ex, input logic [31:0] ax);
    logic [31:0] r, rt, res;
    logic [32:0] sx;
    logic c, v;
    r  = mReg[d];
    rt = ex ? ax : r;
    c = 0; v = 0; res = 0;
    case (op)
      3'd0: begin
        res = r + s; c = (res < s);
        sx = {r[31], r} + {s[31], s}; v = (sx[32] != sx[31]);
        mReg[d] = res;
      end
      3'd1: begin
        res = r - s; c = (s > r);
        sx = {r[31], r} - {s[31], s}; v = (sx[32] != sx[31]);
        mReg[d] = res;
      end
      3'd2: begin
        res = rt - s; c = (s > rt);
        sx = {rt[31], rt} - {s[31], s}; v = (sx[32] != sx[31]);
      end
      3'd3: begin res = r | s; mReg[d] = res; end
      3'd4: begin res = r ^ s; mReg[d] = res; end
      3'd5: res = rt & s;
      default: return;
    endcase
    mStat = {v, c, res[31], (res == 0)};
  endtask

  task automatic doOp(input logic [2:0] op, input logic [1:0] d, input logic [31:0] s,
                      input logic ex, input logic [31:0] ax, input string req);
    @(negedge clk);
    opValid = 1'b1; opCode = op; dstSel = d; srcVal = s; explicitOps = ex; auxVal = ax;
    @(negedge clk);
    opValid = 1'b0;
    model(op, d, s, ex, ax);
    checkState(req);
  endtask

  task automatic testReset();
    for (int i = 0; i < 4; i++) mReg[i] = '0;
    mStat = '0;
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    checkState("R1");
  endtask

  task automatic testAdd();
    doOp(3'd0, 2'd0, 32'd5, 1'b0, 32'd0, "R2 plain");
    doOp(3'd0, 2'd0, 32'hFFFF_FFFB, 1'b0, 32'd0, "R2 wrap zero R7");
    doOp(3'd0, 2'd1, 32'h7FFF_FFFF, 1'b0, 32'd0, "R2");
    doOp(3'd0, 2'd1, 32'd1, 1'b0, 32'd0, "R2 pos overflow");
    doOp(3'd0, 2'd1, 32'h8000_0000, 1'b0, 32'd0, "R2 neg overflow");
    doOp(3'd0, 2'd2, 32'd9, 1'b1, 32'hDEAD_BEEF, "R8 aux ignored on add");
  endtask

  task automatic testSub();
    doOp(3'd1, 2'd3, 32'd1, 1'b0, 32'd0, "R3 borrow");
    doOp(3'd1, 2'd3, 32'hFFFF_FFFF, 1'b0, 32'd0, "R3 zero");
    doOp(3'd0, 2'd3, 32'h8000_0000, 1'b0, 32'd0, "R2");
    doOp(3'd1, 2'd3, 32'd1, 1'b0, 32'd0, "R3 overflow");
    doOp(3'd1, 2'd2, 32'd4, 1'b1, 32'h1234_5678, "R3 R8 aux ignored");
  endtask

  task automatic testCmp();
    doOp(3'd2, 2'd2, 32'd2, 1'b0, 32'd0, "R4 reg right");
    doOp(3'd2, 2'd0, 32'd7, 1'b1, 32'd3, "R4 R8 reversed order borrow");
    doOp(3'd2, 2'd0, 32'd7, 1'b1, 32'd7, "R4 R8 equal");
    doOp(3'd2, 2'd0, 32'd1, 1'b1, 32'h8000_0000, "R4 R8 overflow");
  endtask

  task automatic testLogic();
    doOp(3'd1, 2'd0, 32'd1, 1'b0, 32'd0, "R3 set carry");
    doOp(3'd3, 2'd0, 32'h0F0F_0000, 1'b0, 32'd0, "R5 or clears C");
    doOp(3'd4, 2'd0, 32'hFFFF_FFFF, 1'b0, 32'd0, "R5 xor");
    doOp(3'd4, 2'd1, regsOut[63:32], 1'b0, 32'd0, "R5 xor to zero R7");
    doOp(3'd3, 2'd2, 32'h8000_0001, 1'b1, 32'hAAAA_AAAA, "R5 R8 aux ignored on or");
  endtask

  task automatic testBitTest();
    doOp(3'd0, 2'd3, 32'hFFFF_FFFF, 1'b0, 32'd0, "R2 set carry");
    doOp(3'd5, 2'd2, 32'h8000_0000, 1'b0, 32'd0, "R6 neg");
    doOp(3'd5, 2'd2, 32'h0000_0002, 1'b0, 32'd0, "R6 zero");
    doOp(3'd5, 2'd1, 32'h0000_00F0, 1'b1, 32'h0000_0030, "R6 R8 explicit");
  endtask

  task automatic testIdle();
    doOp(3'd1, 2'd0, 32'h7, 1'b0, 32'd0, "R3");
    @(negedge clk);
    opValid = 1'b0; opCode = 3'd0; dstSel = 2'd0; srcVal = 32'h1111_1111;
    @(negedge clk);
    checkState("R9 valid low");
    doOp(3'd6, 2'd0, 32'h2222_2222, 1'b0, 32'd0, "R9 opcode 6");
    doOp(3'd7, 2'd1, 32'h3333_3333, 1'b1, 32'h1, "R9 opcode 7");
  endtask

  task automatic testSelect();
    for (int i = 0; i < 4; i++)
      doOp(3'd3, 2'(i), 32'h100 << i, 1'b0, 32'd0, "R10 per-register write");
  endtask

  initial begin
    testReset();
    testAdd();
    testSub();
    testCmp();
    testLogic();
    testBitTest();
    testIdle();
    testSelect();
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < 4; i++) mReg[i] = '0;
    mStat = '0;
    checkState("R1 reset after use");
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule